// File: doc/BRIEF.md
# Banked Wiper Register Command Executor

This block carries out decoded commands against one volatile 8-bit wiper register and sixteen 8-bit stored registers, organised as four banks of four. A serial front end, which is outside this block, turns each bus frame into single-cycle events: an instruction byte, an optional data byte, and then either a stop or an abort. The executor answers each accepted instruction with an acknowledge pulse. It returns read data as a one-cycle strobe and drives the wiper position on a parallel output.

Changes to a stored register are held pending until the frame closes with a stop. Only then are they written, and a busy window of a parameterised length follows, standing in for a slow non-volatile store. During that window new instructions get no acknowledge, so a host can poll until the store completes. A write-protect input, active low, blocks every store. The wiper can be loaded from bank 0 or saved into bank 0. It can also be stepped up or down one position at a time while an increment/decrement frame is open.

There are two resets. A power-on reset fills storage with a parameter value. A warm reset leaves storage alone and reloads the wiper from bank 0, register 0.

Top module: `pot_cmd_exec`

## Requirements
- R1: After power-on reset (`por_n` low), every stored register and the wiper hold INIT_VALUE, `busy` is 0 and `cmd_ack` is 0.
- R2: The instruction byte carries the opcode in bits 7:4, the register select in bits 3:2 and the bank select in bits 1:0. An instruction accepted while not busy raises `cmd_ack` for exactly the cycle after `ins_valid`.
- R3: Opcode 1001 returns the wiper value, and opcode 1011 returns the stored register at (bank, register). In both cases `rd_valid` is high with `rd_data` in the cycle after `ins_valid`.
- R4: Opcode 1010 loads the data byte into the wiper in the cycle after `dat_valid`. It starts no busy window.
- R5: Opcode 1100 writes its data byte to the selected stored register only when `stop_evt` closes the frame. `busy` is then high for BUSY_CYCLES cycles, starting the cycle after the stop.
- R6: A frame closed by `abort_evt` changes no stored register and starts no busy window.
- R7: While `wp_n` is low at the stop, no stored register changes and `busy` stays low.
- R8: Opcode 1101 with bank 0 copies the selected bank-0 register into the wiper in the cycle after `ins_valid`. It starts no busy window.
- R9: Opcode 1110 with bank 0 saves the wiper value, as it was at the instruction, into the selected bank-0 register at the stop. The same busy window as R5 follows.
- R10: An opcode outside the set, or a transfer (1101/1110) with a nonzero bank, is acknowledged and changes neither the wiper nor any stored register.
- R11: While `busy` is high, an instruction gets no `cmd_ack`, produces no read strobe and has no effect.
- R12: After opcode 0010 and until the frame closes, each `step_valid` moves the wiper one position up (`step_up`=1) or down (`step_up`=0). The wiper saturates at 255 and 0. Steps outside such a frame are ignored.
- R13: A warm reset (`rst_n` low, `por_n` high) keeps all stored registers and loads the wiper from bank 0, register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; initialises storage |
| rst_n | input | 1 | Warm reset, active low, synchronous; reloads the wiper |
| wp_n | input | 1 | Write protect, low blocks stores |
| ins_valid | input | 1 | Instruction byte strobe |
| ins_byte | input | 8 | Instruction byte |
| dat_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte |
| stop_evt | input | 1 | Frame closed by a stop |
| abort_evt | input | 1 | Frame closed without a stop |
| step_valid | input | 1 | One increment/decrement step |
| step_up | input | 1 | Step direction, 1 moves up |
| cmd_ack | output | 1 | Instruction acknowledge pulse |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 8 | Read data |
| wiper | output | 8 | Current wiper position |
| busy | output | 1 | Store window in progress |

## Verification
A corrupted pending index or data shows up only after the stop and the busy window, when the next read of the target register returns the wrong byte. The bench reads back every store target, and also a neighbour that must not change. A phase register stuck in the wrong state shows up within one cycle as a wrong wiper value, a missing or extra acknowledge, or an unexpected read strobe. The scoreboard flags any unexpected read strobe at once. A timer fault is visible as `busy` present or absent right after a stop, and as polling that never ends.

// File: rtl/pot_pkg.sv
package pot_pkg;
    localparam int DATA_W       = 8;
    localparam int REGS_PER_BNK = 4;
    localparam int BANK_CNT     = 4;
    localparam int REG_CNT      = REGS_PER_BNK * BANK_CNT;
    localparam int IDX_W        = $clog2(REG_CNT);

    localparam logic [3:0] OP_RD_WIPER = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER = 4'b1010;
    localparam logic [3:0] OP_RD_STORE = 4'b1011;
    localparam logic [3:0] OP_WR_STORE = 4'b1100;
    localparam logic [3:0] OP_LOAD     = 4'b1101;
    localparam logic [3:0] OP_SAVE     = 4'b1110;
    localparam logic [3:0] OP_STEP     = 4'b0010;

    typedef enum logic [2:0] {
        K_NONE, K_RD_WIPER, K_WR_WIPER, K_RD_STORE,
        K_WR_STORE, K_LOAD, K_SAVE, K_STEP
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [IDX_W-1:0]  idx;
    } cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_DATA_WIPER, PH_DATA_STORE, PH_COMMIT, PH_STEP, PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [DATA_W-1:0]  wiper;
        logic [DATA_W-1:0]  pend_data;
        logic [IDX_W-1:0]   pend_idx;
        logic               ack;
        logic               rd_valid;
        logic [DATA_W-1:0]  rd_data;
    } ctl_t;
endpackage

// File: rtl/pot_cmd_decode.sv
module pot_cmd_decode
    import pot_pkg::*;
(
    input  logic [7:0] ins_byte,
    output cmd_t       cmd
);
    logic [3:0] opc;
    logic [1:0] reg_sel;
    logic [1:0] bank_sel;
    logic       bank_zero;

    always_comb begin
        opc       = ins_byte[7:4];
        reg_sel   = ins_byte[3:2];
        bank_sel  = ins_byte[1:0];
        bank_zero = (bank_sel == 2'b00);
        cmd.idx   = IDX_W'({bank_sel, reg_sel});
        unique case (opc)
            OP_RD_WIPER: cmd.kind = K_RD_WIPER;
            OP_WR_WIPER: cmd.kind = K_WR_WIPER;
            OP_RD_STORE: cmd.kind = K_RD_STORE;
            OP_WR_STORE: cmd.kind = K_WR_STORE;
            OP_LOAD:     cmd.kind = bank_zero ? K_LOAD : K_NONE;
            OP_SAVE:     cmd.kind = bank_zero ? K_SAVE : K_NONE;
            OP_STEP:     cmd.kind = K_STEP;
            default:     cmd.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/pot_store_bank.sv
module pot_store_bank #(
    parameter int                DATA_W     = 8,
    parameter int                ENTRIES    = 16,
    parameter logic [DATA_W-1:0] INIT_VALUE = '0,
    localparam int               IDX_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] home
);
    logic [DATA_W-1:0] cell_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        logic [DATA_W-1:0] cell_d;
        always_comb begin
            cell_d = cell_q[i];
            if (we && (widx == IDX_W'(i))) cell_d = wdata;
        end
        always_ff @(posedge clk) begin
            if (!por_n) cell_q[i] <= INIT_VALUE;
            else        cell_q[i] <= cell_d;
        end
    end

    always_comb begin
        rdata = cell_q[ridx];
        home  = cell_q[0];
    end
endmodule

// File: rtl/pot_busy_timer.sv
module pot_busy_timer #(
    parameter int  CYCLES = 500000,
    localparam int CW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pot_cmd_exec.sv
module pot_cmd_exec
    import pot_pkg::*;
#(
    parameter int                BUSY_CYCLES = 500000,
    parameter logic [DATA_W-1:0] INIT_VALUE  = 8'h80
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              ins_valid,
    input  logic [7:0]        ins_byte,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_byte,
    input  logic              stop_evt,
    input  logic              abort_evt,
    input  logic              step_valid,
    input  logic              step_up,
    output logic              cmd_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wiper,
    output logic              busy
);
    localparam logic [DATA_W-1:0] WIPER_MAX = '1;

    ctl_t              q, d;
    cmd_t              cmd;
    logic              commit;
    logic              ctl_rst_n;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] store_home;

    assign ctl_rst_n = rst_n & por_n;

    pot_cmd_decode u_dec (
        .ins_byte (ins_byte),
        .cmd      (cmd)
    );

    pot_store_bank #(
        .DATA_W     (DATA_W),
        .ENTRIES    (REG_CNT),
        .INIT_VALUE (INIT_VALUE)
    ) u_bank (
        .clk   (clk),
        .por_n (por_n),
        .we    (commit),
        .widx  (q.pend_idx),
        .wdata (q.pend_data),
        .ridx  (cmd.idx),
        .rdata (store_rdata),
        .home  (store_home)
    );

    pot_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (ctl_rst_n),
        .start (commit),
        .busy  (busy)
    );

    always_comb begin
        d          = q;
        d.ack      = 1'b0;
        d.rd_valid = 1'b0;
        commit     = 1'b0;

        unique case (q.phase)
            PH_IDLE: begin
                if (ins_valid && !busy) begin
                    d.ack      = 1'b1;
                    d.pend_idx = cmd.idx;
                    d.phase    = PH_DONE;
                    unique case (cmd.kind)
                        K_RD_WIPER: begin
                            d.rd_valid = 1'b1;
                            d.rd_data  = q.wiper;
                        end
                        K_RD_STORE: begin
                            d.rd_valid = 1'b1;
                            d.rd_data  = store_rdata;
                        end
                        K_WR_WIPER: d.phase = PH_DATA_WIPER;
                        K_WR_STORE: d.phase = PH_DATA_STORE;
                        K_LOAD:     d.wiper = store_rdata;
                        K_SAVE: begin
                            d.pend_data = q.wiper;
                            d.phase     = PH_COMMIT;
                        end
                        K_STEP:     d.phase = PH_STEP;
                        default:    d.phase = PH_DONE;
                    endcase
                end
            end
            PH_DATA_WIPER: begin
                if (dat_valid) begin
                    d.wiper = dat_byte;
                    d.phase = PH_DONE;
                end
            end
            PH_DATA_STORE: begin
                if (dat_valid) begin
                    d.pend_data = dat_byte;
                    d.phase     = PH_COMMIT;
                end
            end
            PH_STEP: begin
                if (step_valid) begin
                    if (step_up && (q.wiper != WIPER_MAX))
                        d.wiper = q.wiper + 1'b1;
                    else if (!step_up && (q.wiper != '0))
                        d.wiper = q.wiper - 1'b1;
                end
            end
            default: ;
        endcase

        if (stop_evt && (q.phase == PH_COMMIT) && wp_n)
            commit = 1'b1;

        if (stop_evt || abort_evt)
            d.phase = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!ctl_rst_n) begin
            q.phase     <= PH_IDLE;
            q.wiper     <= por_n ? store_home : INIT_VALUE;
            q.pend_data <= '0;
            q.pend_idx  <= '0;
            q.ack       <= 1'b0;
            q.rd_valid  <= 1'b0;
            q.rd_data   <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ack  = q.ack;
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign wiper    = q.wiper;
endmodule

// File: rtl/pot_cmd_exec_chk.sv
module pot_cmd_exec_chk (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       wp_n,
    input logic       ins_valid,
    input logic       dat_valid,
    input logic       stop_evt,
    input logic       step_valid,
    input logic       step_up,
    input logic       cmd_ack,
    input logic       rd_valid,
    input logic [7:0] wiper,
    input logic       busy
);
    AST_ACK_FROM_INS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        cmd_ack |-> $past(ins_valid)); // R2
    AST_READ_FROM_INS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rd_valid |-> $past(ins_valid)); // R3
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(busy) |-> $past(stop_evt)); // R5
    AST_WP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (stop_evt && !wp_n && !busy) |=> !busy); // R7
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (ins_valid && busy) |=> !cmd_ack); // R11
    AST_STEP_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (step_valid && step_up && !ins_valid && !dat_valid && wiper == 8'hFF)
        |=> wiper == 8'hFF); // R12
    AST_STEP_BOT_SAT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (step_valid && !step_up && !ins_valid && !dat_valid && wiper == 8'h00)
        |=> wiper == 8'h00); // R12
endmodule

bind pot_cmd_exec pot_cmd_exec_chk u_chk (.*);

// File: tb/pot_cmd_exec_test.sv
module pot_cmd_exec_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CYC   = 40;

    logic       clk = 0;
    logic       por_n = 0, rst_n = 0, wp_n = 1;
    logic       ins_valid = 0, dat_valid = 0, stop_evt = 0, abort_evt = 0;
    logic       step_valid = 0, step_up = 0;
    logic [7:0] ins_byte = 0, dat_byte = 0;
    logic       cmd_ack, rd_valid, busy;
    logic [7:0] rd_data, wiper;

    int n_tests = 0, n_fail = 0;
    logic ack_seen;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pot_cmd_exec #(.BUSY_CYCLES(BUSY_CYC), .INIT_VALUE(8'h80)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wp_n(wp_n),
        .ins_valid(ins_valid), .ins_byte(ins_byte),
        .dat_valid(dat_valid), .dat_byte(dat_byte),
        .stop_evt(stop_evt), .abort_evt(abort_evt),
        .step_valid(step_valid), .step_up(step_up),
        .cmd_ack(cmd_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .wiper(wiper), .busy(busy)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data on each strobe
    always @(negedge clk) begin
        if (rd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R11 unexpected read strobe", rd_data, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic send_ins(logic [7:0] b);
        @(negedge clk); ins_valid = 1; ins_byte = b;
        @(negedge clk); ins_valid = 0; ack_seen = cmd_ack;
    endtask
    task automatic send_dat(logic [7:0] b);
        @(negedge clk); dat_valid = 1; dat_byte = b;
        @(negedge clk); dat_valid = 0;
    endtask
    task automatic send_stop();
        @(negedge clk); stop_evt = 1;
        @(negedge clk); stop_evt = 0;
    endtask
    task automatic send_abort();
        @(negedge clk); abort_evt = 1;
        @(negedge clk); abort_evt = 0;
    endtask
    task automatic step(logic up);
        @(negedge clk); step_valid = 1; step_up = up;
        @(negedge clk); step_valid = 0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 4 * BUSY_CYC && busy; i++) @(negedge clk);
    endtask
    task automatic expect_read(logic [7:0] ins, logic [7:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        send_ins(ins);
        send_stop();
    endtask
    task automatic write_frame(logic [7:0] ins, logic [7:0] data);
        send_ins(ins); send_dat(data); send_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
        @(negedge clk);
        chk("R1 wiper after power-on", wiper, 8'h80);
        chk("R1 busy after power-on", {7'd0, busy}, 8'h00);
        chk("R1 ack after power-on", {7'd0, cmd_ack}, 8'h00);
        expect_read(8'hBB, 8'h80, "R1 bank3 reg2 initial");

        write_frame(8'hA0, 8'h33);
        chk("R4 wiper written", wiper, 8'h33);
        chk("R4 no busy", {7'd0, busy}, 8'h00);
        expect_read(8'h90, 8'h33, "R3 read wiper");
        chk("R2 ack on read", {7'd0, ack_seen}, 8'h01);

        // store bank1 reg2: 1100_10_01
        send_ins(8'hC9); send_dat(8'h5C);
        chk("R5 no busy before stop", {7'd0, busy}, 8'h00);
        send_stop();
        chk("R5 busy after stop", {7'd0, busy}, 8'h01);
        send_ins(8'h90);
        chk("R11 no ack while busy", {7'd0, ack_seen}, 8'h00);
        send_stop();
        wait_idle();
        chk("R5 busy ends", {7'd0, busy}, 8'h00);
        expect_read(8'hB9, 8'h5C, "R5 stored readback");
        expect_read(8'hB8, 8'h80, "R5 neighbour untouched");

        send_ins(8'hC0); send_dat(8'h11); send_abort();
        chk("R6 no busy after abort", {7'd0, busy}, 8'h00);
        expect_read(8'hB0, 8'h80, "R6 aborted store");

        wp_n = 0;
        write_frame(8'hC0, 8'h22);
        chk("R7 no busy when protected", {7'd0, busy}, 8'h00);
        wp_n = 1;
        expect_read(8'hB0, 8'h80, "R7 protected store");

        write_frame(8'hC4, 8'h7E); wait_idle();
        send_ins(8'hD4);
        chk("R8 wiper loaded", wiper, 8'h7E);
        send_stop();
        chk("R8 no busy", {7'd0, busy}, 8'h00);

        write_frame(8'hA0, 8'h44);
        send_ins(8'hD5);
        chk("R10 ack bad bank", {7'd0, ack_seen}, 8'h01);
        chk("R10 wiper kept bad bank", wiper, 8'h44);
        send_stop();
        send_ins(8'hF0);
        chk("R10 ack unknown op", {7'd0, ack_seen}, 8'h01);
        send_stop();
        chk("R10 wiper kept unknown op", wiper, 8'h44);

        send_ins(8'hEC); send_stop();
        chk("R9 busy after save", {7'd0, busy}, 8'h01);
        wait_idle();
        expect_read(8'hBC, 8'h44, "R9 saved wiper");
        send_ins(8'hED); send_stop();
        chk("R10 no busy bad-bank save", {7'd0, busy}, 8'h00);
        expect_read(8'hBD, 8'h80, "R10 bad-bank save untouched");

        write_frame(8'hA0, 8'hFE);
        send_ins(8'h20);
        step(1); step(1); step(1);
        chk("R12 saturate high", wiper, 8'hFF);
        step(0);
        chk("R12 step down", wiper, 8'hFE);
        send_stop();
        step(0);
        chk("R12 step outside mode", wiper, 8'hFE);
        write_frame(8'hA0, 8'h01);
        send_ins(8'h20);
        step(0); step(0);
        chk("R12 saturate low", wiper, 8'h00);
        send_stop();

        write_frame(8'hC0, 8'h5A); wait_idle();
        write_frame(8'hA0, 8'h10);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R13 wiper from bank0 reg0", wiper, 8'h5A);
        expect_read(8'hB9, 8'h5C, "R13 storage kept");

        repeat (3) @(negedge clk);
        chk("R3 all reads seen", 8'(exp_q.size()), 8'h00);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule